// File: doc/BRIEF.md
# Bidirectional Rotating Register with Parallel Load

The block is a register of `WIDTH` bits (eight by default) built from identical bit-slices. Each slice holds one flip-flop, preceded by a neighbour-select multiplexer and a data-select multiplexer. On every rising clock edge the register performs exactly one action:

- synchronous clear;
- parallel load;
- left rotation with wrap-around;
- right rotation with wrap-around;
- arithmetic right shift that keeps the top bit and copies it downward.

The register is used wherever a stored word must be turned in either direction, or halved with its sign kept. Which action happens is set by four control levels that are sampled at the edge: an active-high clear, an active-low load, a direction select and an arithmetic-fill select. Only the top slice sees the arithmetic-fill select. It changes that slice's right-move source from the bottom bit to the top bit itself, and it has no effect during a left move.

Top module: `ring_shift_reg`

## Requirements
- R1: When `rst` is 1 at a rising edge, `q` becomes all zeros, whatever the other controls are.
- R2: When `rst` is 0 and `load_n` is 0 at a rising edge, `q` takes the value of `din`, regardless of `rot_right` and `arith_shr`.
- R3: When `rst` is 0, `load_n` is 1, `rot_right` is 1 and `arith_shr` is 0, each edge moves every bit one place toward bit 0, and the old bit 0 enters the top bit. For example, 8'h81 becomes 8'hC0.
- R4: When `rst` is 0, `load_n` is 1, `rot_right` is 1 and `arith_shr` is 1, each edge moves every bit one place toward bit 0, and the top bit keeps its old value. For example, 8'h81 becomes 8'hC0, and 8'h41 becomes 8'h20.
- R5: When `rst` is 0, `load_n` is 1 and `rot_right` is 0, each edge moves every bit one place toward the top, and the old top bit enters bit 0. `arith_shr` has no effect in this mode. For example, 8'h81 becomes 8'h03.
- R6: `WIDTH` consecutive rotations in one direction return `q` to the value it had before them.
- R7: After `WIDTH-1` consecutive arithmetic shifts, a value whose top bit is 1 becomes all ones, and a value whose top bit is 0 becomes all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous clear, active high |
| load_n | input | 1 | Parallel load, active low |
| rot_right | input | 1 | 1 selects a move toward bit 0, 0 selects a move toward the top |
| arith_shr | input | 1 | 1 makes a right move keep the top bit instead of wrapping bit 0 |
| din | input | WIDTH | Parallel load data |
| q | output | WIDTH | Register contents |

## Verification
The hardest case to reach is the one where the arithmetic-fill select is high while the register moves left. A wrong wiring there changes only one bit, and only when the top and bottom bits differ. The bench loads words whose two end bits differ, then holds the fill select high through a full run of left rotations. Random stimulus also toggles the fill select freely in both directions, so the shortcut the top slice takes is exercised against many patterns.

// File: rtl/ring_shift_pkg.sv
package ring_shift_pkg;

    // Decoded per-edge control shared by every slice
    typedef struct packed {
        logic clear;      // force zero
        logic take_data;  // select parallel data bit
        logic go_right;   // neighbour source is the higher-index bit
        logic msb_fill;   // top slice keeps itself on a right move
    } slice_ctrl_t;

    // Registered state of one slice
    typedef struct packed {
        logic bit_v;
    } slice_state_t;

endpackage

// File: rtl/rsr_ctrl.sv
module rsr_ctrl
    import ring_shift_pkg::*;
(
    input  logic        rst,
    input  logic        load_n,
    input  logic        rot_right,
    input  logic        arith_shr,
    output slice_ctrl_t ctrl
);

    always_comb begin
        ctrl           = '0;
        ctrl.clear     = rst;
        ctrl.take_data = ~load_n;
        ctrl.go_right  = rot_right;
        // the fill select matters only when moving toward bit 0 (R5)
        ctrl.msb_fill  = arith_shr & rot_right;
    end

endmodule

// File: rtl/rsr_slice.sv
module rsr_slice
    import ring_shift_pkg::*;
(
    input  logic        clk,
    input  slice_ctrl_t ctrl,
    input  logic        nbr_hi,    // bit above this one (right move source)
    input  logic        nbr_lo,    // bit below this one (left move source)
    input  logic        data_bit,
    output logic        q_bit
);

    slice_state_t state_d, state_q;
    logic         moved_d;

    always_comb begin
        moved_d = ctrl.go_right ? nbr_hi : nbr_lo;
        state_d = state_q;
        if (ctrl.clear) begin
            state_d.bit_v = 1'b0;
        end else if (ctrl.take_data) begin
            state_d.bit_v = data_bit;
        end else begin
            state_d.bit_v = moved_d;
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign q_bit = state_q.bit_v;

    // R1: clear wins inside the slice
    a_r1_slice_clear: assert property (@(posedge clk)
        ctrl.clear |=> !q_bit);

    // R2: load takes the data bit when not cleared
    a_r2_slice_load: assert property (@(posedge clk) disable iff (ctrl.clear)
        ctrl.take_data |=> q_bit == $past(data_bit));

endmodule

// File: rtl/ring_shift_reg.sv
module ring_shift_reg
    import ring_shift_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_n,
    input  logic             rot_right,
    input  logic             arith_shr,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] q
);

    localparam int TOP = WIDTH - 1;

    slice_ctrl_t      ctrl;
    logic [WIDTH-1:0] src_hi;
    logic [WIDTH-1:0] src_lo;

    rsr_ctrl u_ctrl (
        .rst       (rst),
        .load_n    (load_n),
        .rot_right (rot_right),
        .arith_shr (arith_shr),
        .ctrl      (ctrl)
    );

    for (genvar i = 0; i < WIDTH; i++) begin : g_slice
        // source for a right move: the bit above, ring or fill at the top
        if (i == TOP) begin : g_top
            assign src_hi[i] = ctrl.msb_fill ? q[TOP] : q[0];
        end else begin : g_mid_hi
            assign src_hi[i] = q[i+1];
        end
        // source for a left move: the bit below, ring at the bottom
        if (i == 0) begin : g_bot
            assign src_lo[i] = q[TOP];
        end else begin : g_mid_lo
            assign src_lo[i] = q[i-1];
        end

        rsr_slice u_slice (
            .clk      (clk),
            .ctrl     (ctrl),
            .nbr_hi   (src_hi[i]),
            .nbr_lo   (src_lo[i]),
            .data_bit (din[i]),
            .q_bit    (q[i])
        );
    end

    // R1: clear to zero at the edge
    a_r1_clear: assert property (@(posedge clk)
        rst |=> q == '0);

    // R2: load has priority over all moves
    a_r2_load: assert property (@(posedge clk) disable iff (rst)
        !load_n |=> q == $past(din));

    // R3: right rotation wraps bit 0 into the top
    a_r3_rotr: assert property (@(posedge clk) disable iff (rst)
        (load_n && rot_right && !arith_shr) |=>
        q == {$past(q[0]), $past(q[TOP:1])});

    // R4: arithmetic shift keeps the top bit
    a_r4_asr: assert property (@(posedge clk) disable iff (rst)
        (load_n && rot_right && arith_shr) |=>
        q == {$past(q[TOP]), $past(q[TOP:1])});

    // R5: left rotation wraps the top into bit 0, fill select ignored
    a_r5_rotl: assert property (@(posedge clk) disable iff (rst)
        (load_n && !rot_right) |=>
        q == {$past(q[TOP-1:0]), $past(q[TOP])});

    // R6: any rotation keeps the number of ones
    a_r6_ones_kept: assert property (@(posedge clk) disable iff (rst)
        (load_n && !(rot_right && arith_shr)) |=>
        $countones(q) == $countones($past(q)));

endmodule

// File: tb/ring_shift_reg_tb.sv
module ring_shift_reg_tb;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         load_n = 1'b1;
    logic         rot_right = 1'b0;
    logic         arith_shr = 1'b0;
    logic [W-1:0] din = '0;
    logic [W-1:0] q;

    int           n_run = 0;
    int           n_fail = 0;
    int           cyc = 0;
    bit           done = 1'b0;
    logic [W-1:0] exp_q = '0;

    always #5 clk = ~clk;

    ring_shift_reg #(.WIDTH(W)) u_dut (
        .clk(clk), .rst(rst), .load_n(load_n), .rot_right(rot_right),
        .arith_shr(arith_shr), .din(din), .q(q)
    );

    function automatic logic [W-1:0] model(input logic [W-1:0] cur,
        input logic r, input logic ln, input logic rr, input logic ar,
        input logic [W-1:0] d);
        if (r) return '0;
        if (!ln) return d;
        if (rr && ar) return {cur[W-1], cur[W-1:1]};
        if (rr) return {cur[0], cur[W-1:1]};
        return {cur[W-2:0], cur[W-1]};
    endfunction

    task automatic check(input string tag, input logic [W-1:0] want);
        n_run++;
        if (q !== want) begin
            n_fail++;
            $display("FAIL %s: q=%h expected=%h", tag, q, want);
        end
    endtask

    // drive at negedge, clock, then sample after the edge
    task automatic step(input logic r, input logic ln, input logic rr,
                        input logic ar, input logic [W-1:0] d);
        @(negedge clk);
        rst = r; load_n = ln; rot_right = rr; arith_shr = ar; din = d;
        exp_q = model(exp_q, r, ln, rr, ar, d);
        @(posedge clk);
        #1;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog: expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] start;
        int unsigned  seed;
        seed = 32'd20240611;
        void'($urandom(seed));

        // R1: reset state
        step(1, 1, 0, 0, 8'h00);
        check("R1 reset", 8'h00);

        // R2: load with move controls also active
        step(0, 0, 1, 1, 8'h81);
        check("R2 load priority", 8'h81);

        // R3: right rotate example
        step(0, 1, 1, 0, 8'h00);
        check("R3 rotr", 8'hC0);

        // R6 + R3: full right ring returns start
        step(0, 0, 0, 0, 8'h96);
        start = exp_q;
        for (int i = 0; i < W; i++) begin
            step(0, 1, 1, 0, 8'h00);
            check("R3 rotr run", exp_q);
        end
        check("R6 right ring", start);

        // R5 + R6: left ring with fill select high (must be ignored)
        step(0, 0, 0, 0, 8'h81);
        step(0, 1, 0, 1, 8'h00);
        check("R5 rotl fill ignored", 8'h03);
        step(0, 0, 0, 0, 8'h6B);
        start = exp_q;
        for (int i = 0; i < W; i++) begin
            step(0, 1, 0, 1, 8'h00);
            check("R5 rotl run", exp_q);
        end
        check("R6 left ring", start);

        // R4: arithmetic shift examples
        step(0, 0, 0, 0, 8'h41);
        step(0, 1, 1, 1, 8'h00);
        check("R4 asr msb0", 8'h20);
        step(0, 0, 0, 0, 8'h81);
        step(0, 1, 1, 1, 8'h00);
        check("R4 asr msb1", 8'hC0);

        // R7: convergence to ones and to zeros
        step(0, 0, 0, 0, 8'h80);
        for (int i = 0; i < W - 1; i++) step(0, 1, 1, 1, 8'h00);
        check("R7 converge ones", 8'hFF);
        step(0, 0, 0, 0, 8'h7F);
        for (int i = 0; i < W - 1; i++) step(0, 1, 1, 1, 8'h00);
        check("R7 converge zeros", 8'h00);

        // R1: reset beats load
        step(0, 0, 0, 0, 8'hFF);
        step(1, 0, 1, 1, 8'hAA);
        check("R1 reset over load", 8'h00);

        // random mix, all requirements R1..R5
        for (int i = 0; i < 600; i++) begin
            logic [3:0] pick;
            pick = 4'($urandom);
            step(pick == 0, pick < 3, $urandom % 2 == 1,
                 $urandom % 2 == 1, W'($urandom));
            check("R1-R5 random", exp_q);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule